// File: doc/BRIEF.md
# Dual-Tone Sine Test Generator

The block produces a test waveform for a 14-bit digital-to-analog converter by adding two sine tones. Two phase-accumulator oscillators share one clock. The second oscillator is locked to exactly ten times the frequency of the first. Both tones have the same amplitude, a 13-bit signed range. Their sum is formed in 14 bits without overflow and then re-encoded as unsigned offset binary, so the converter sees midscale for a zero sum.

The caller supplies a base phase increment that sets the slow tone frequency. While the enable input is high, both accumulators advance once per clock. One cycle after each advance the block presents a new converter code and pulses a valid strobe. While enable is low, everything holds. The sine values come from a quarter-wave table that is computed at elaboration, and symmetry folding covers the full cycle.

Top module: `dual_tone_gen`

## Requirements
- R1: A synchronous reset clears both phase accumulators, drives the converter code to midscale 8192 and holds the valid strobe low.
- R2: On every clock edge where enable is high, the slow phase accumulator (32 bits) advances by the base increment, modulo 2^32.
- R3: On each such edge, the fast accumulator advances by ten times the base increment, modulo 2^32. The fast phase therefore always equals ten times the slow phase, modulo 2^32.
- R4: Each tone sample is signed, 13 bits wide and limited to -4095..+4095. It is addressed by the top 10 bits `a` of its accumulator, and its value is round(4095·sin(2π(a+0.5)/1024)) to within one code.
- R5: The two samples are sign-extended and added in 14 bits. Because each magnitude is at most 4095, the sum stays within -8190..+8190 and never wraps.
- R6: The converter code is the 14-bit sum with its most significant bit inverted (offset binary). A sum of 0 gives 8192, and positive sums give codes above 8192.
- R7: While enable is low, both accumulators and the converter code keep their values.
- R8: The valid strobe is high exactly in the cycle after an accumulator update. The code presented with it is computed from the phases that update produced.
- R9: A new base increment takes effect at the first enabled edge after it is applied, with no restart of the phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both oscillators |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the oscillators on this edge |
| base_inc_i | input | 32 | Phase increment of the slow tone |
| dac_code_o | output | 14 | Unsigned offset-binary converter code |
| dac_valid_o | output | 1 | New code strobe, one cycle after an update |

## Verification
The assertions assume that reset is held for at least one edge before enable rises, and that the inputs are stable at each rising edge. The bench drives all inputs on the falling edge and starts from a reset pulse, so both conditions hold. The base increment may take any 32-bit value. The stimulus covers a zero increment, small and large increments that wrap the fast accumulator often, and an increment near 2^32/9 that keeps both tones almost aligned so the sum reaches its extremes. It also includes irregular enable patterns and increments that change in mid-run.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // pi scaled by 2^30
    localparam longint PI_FX = 64'sd3373259426;

    // Quarter-wave magnitude at index k: amp * sin((2k+1)*pi / 2^(qbits+2)),
    // evaluated with a fixed-point odd power series (scale 2^30).
    function automatic int quarter_sample(input int k, input int qbits, input int amp);
        longint th;
        longint th2;
        longint term;
        longint acc;
        th   = (longint'(2 * k + 1) * PI_FX) >>> (qbits + 2);
        th2  = (th * th) >>> 30;
        term = th;
        acc  = th;
        for (int n = 1; n <= 6; n++) begin
            term = (term * th2) >>> 30;
            term = term / longint'((2 * n) * (2 * n + 1));
            if (n % 2 == 1) acc = acc - term;
            else            acc = acc + term;
        end
        return int'((acc * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/dtg_sine_rom.sv
module dtg_sine_rom #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 13
) (
    input  logic [ADDR_W-1:0]        addr_i,
    output logic signed [AMP_W-1:0]  sample_o
);
    localparam int QB      = ADDR_W - 2;
    localparam int QLEN    = 2 ** QB;
    localparam int MAG_W   = AMP_W - 1;
    localparam int AMP_MAX = 2 ** MAG_W - 1;

    logic [MAG_W-1:0] qtab [QLEN];

    for (genvar g = 0; g < QLEN; g++) begin : g_tab
        assign qtab[g] = MAG_W'(dtg_pkg::quarter_sample(g, QB, AMP_MAX));
    end

    logic [1:0]          quad;
    logic [QB-1:0]       idx;
    logic [QB-1:0]       fold_idx;
    logic signed [AMP_W-1:0] mag_ext;

    always_comb begin
        quad     = addr_i[ADDR_W-1 -: 2];
        idx      = addr_i[QB-1:0];
        fold_idx = quad[0] ? ~idx : idx;
        mag_ext  = $signed({1'b0, qtab[fold_idx]});
        sample_o = quad[1] ? -mag_ext : mag_ext;
    end

endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int AMP_W   = 13,
    parameter int OUT_W   = 14,
    parameter int RATIO   = 10
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] base_inc_i,
    output logic [OUT_W-1:0]   dac_code_o,
    output logic               dac_valid_o
);
    localparam int NTONE   = 2;
    localparam int AMP_MAX = 2 ** (AMP_W - 1) - 1;
    localparam int SUM_MAX = 2 * AMP_MAX;
    localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

    typedef struct packed {
        logic [PHASE_W-1:0] slow;
        logic [PHASE_W-1:0] fast;
        logic               upd;
        logic [OUT_W-1:0]   dac;
        logic               vld;
    } state_t;

    state_t st_d, st_q;

    logic [PHASE_W-1:0] fast_inc;
    logic [PHASE_W-1:0] phase [NTONE];
    logic signed [AMP_W-1:0] smp [NTONE];
    logic signed [OUT_W-1:0] mix;

    assign fast_inc = base_inc_i * PHASE_W'(RATIO);
    assign phase[0] = st_q.slow;
    assign phase[1] = st_q.fast;

    for (genvar t = 0; t < NTONE; t++) begin : g_tone
        dtg_sine_rom #(
            .ADDR_W (ADDR_W),
            .AMP_W  (AMP_W)
        ) rom_i (
            .addr_i   (phase[t][PHASE_W-1 -: ADDR_W]),
            .sample_o (smp[t])
        );
    end

    always_comb begin
        mix = {{(OUT_W - AMP_W){smp[0][AMP_W-1]}}, smp[0]}
            + {{(OUT_W - AMP_W){smp[1][AMP_W-1]}}, smp[1]};
        st_d     = st_q;
        st_d.upd = en_i;
        st_d.vld = st_q.upd;
        if (st_q.upd) begin
            st_d.dac = {~mix[OUT_W-1], mix[OUT_W-2:0]};
        end
        if (en_i) begin
            st_d.slow = st_q.slow + base_inc_i;
            st_d.fast = st_q.fast + fast_inc;
        end
        if (rst_i) begin
            st_d.slow = '0;
            st_d.fast = '0;
            st_d.upd  = 1'b0;
            st_d.dac  = MID;
            st_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign dac_code_o  = st_q.dac;
    assign dac_valid_o = st_q.vld;

    // ---------------- assertions ----------------
    assert_reset_mid_R1: assert property (@(posedge clk_i)
        rst_i |=> (dac_code_o == MID && !dac_valid_o));

    assert_slow_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> st_q.slow == PHASE_W'($past(st_q.slow) + $past(base_inc_i)));

    assert_fast_lock_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.fast == PHASE_W'(st_q.slow * PHASE_W'(RATIO)));

    assert_sample_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp[0] >= -AMP_MAX && smp[0] <= AMP_MAX &&
         smp[1] >= -AMP_MAX && smp[1] <= AMP_MAX));

    assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (mix >= -SUM_MAX && mix <= SUM_MAX));

    assert_phase_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(st_q.slow) && $stable(st_q.fast)));

    assert_code_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.upd |=> $stable(dac_code_o));

    assert_valid_lag_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.upd |=> dac_valid_o);

    assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.upd |=> !dac_valid_o);

endmodule

// File: tb/dual_tone_gen_tb.sv
`timescale 1ns/1ps
module dual_tone_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] inc = '0;
    logic [13:0] dac;
    logic        vld;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    dual_tone_gen dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .en_i        (en),
        .base_inc_i  (inc),
        .dac_code_o  (dac),
        .dac_valid_o (vld)
    );

    // reference state
    longint m_slow = 0;
    longint m_fast = 0;
    bit     m_upd  = 0;
    real    m_dac  = 8192.0;
    bit     m_vld  = 0;
    string  tag    = "R1";

    function automatic real tone(input longint ph);
        longint a;
        a = (ph >> 22) & 1023;
        return 4095.0 * $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 1024.0);
    endfunction

    task automatic compare();
        real diff;
        total++;
        diff = $itor(dac) - m_dac;
        if (diff > 2.5 || diff < -2.5) begin
            bad++;
            $display("FAIL %s dac actual=%0d expected=%0.2f", tag, dac, m_dac);
        end
        total++;
        if (vld !== m_vld) begin
            bad++;
            $display("FAIL R8 valid actual=%0b expected=%0b", vld, m_vld);
        end
    endtask

    // one clock: drive inputs now (falling edge), update model at the rising edge
    task automatic step(input bit e, input logic [31:0] i);
        en  = e;
        inc = i;
        @(posedge clk);
        if (rst) begin
            m_slow = 0; m_fast = 0; m_upd = 0; m_dac = 8192.0; m_vld = 0;
        end else begin
            m_vld = m_upd;
            if (m_upd) m_dac = 8192.0 + tone(m_slow) + tone(m_fast);
            if (e) begin
                m_slow = (m_slow + longint'(i)) & 64'hFFFF_FFFF;
                m_fast = (m_fast + 10 * longint'(i)) & 64'hFFFF_FFFF;
            end
            m_upd = e;
        end
        @(negedge clk);
        compare();
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        // R1: reset holds midscale and no strobe
        tag = "R1";
        for (int k = 0; k < 4; k++) step(1'b1, 32'h1234_5678);
        rst = 1'b0;
        step(1'b0, 32'h0);
        // R6: zero increment, both tones at address 0 -> small positive sum above midscale
        tag = "R6";
        for (int k = 0; k < 6; k++) step(1'b1, 32'h0);
        total++;
        if (dac <= 14'd8192) begin
            bad++;
            $display("FAIL R6 code actual=%0d expected=>8192", dac);
        end
        // R2: slow sweep
        tag = "R2";
        for (int k = 0; k < 500; k++) step(1'b1, 32'h0010_0000);
        // R3: fast accumulator wraps often
        tag = "R3";
        for (int k = 0; k < 400; k++) step(1'b1, 32'h0123_4567);
        // R7: irregular enable, holds in between
        tag = "R7";
        for (int k = 0; k < 400; k++) step((k % 3 != 0) && (k % 7 != 2), 32'h0FED_CBA9);
        for (int k = 0; k < 5; k++) step(1'b0, 32'hFFFF_FFFF);
        // R9: increment changes mid-run
        tag = "R9";
        for (int k = 0; k < 300; k++) step(1'b1, 32'h0003_0000 + 32'(k / 7) * 32'h0051_1F03);
        // R4: quarter steps hit peaks and sign changes
        tag = "R4";
        for (int k = 0; k < 40; k++) step(1'b1, 32'h4000_0000);
        // R5: near-aligned tones reach the sum extremes
        tag = "R5";
        for (int k = 0; k < 1200; k++) step(1'b1, 32'h1C71_C71C);
        // R1 again: reset mid-run
        tag = "R1";
        rst = 1'b1;
        step(1'b1, 32'h1C71_C71C);
        step(1'b0, 32'h0);
        rst = 1'b0;
        tag = "R8";
        for (int k = 0; k < 30; k++) step(k[0], 32'h0800_0000);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule